// File: doc/BRIEF.md
# Dual Performance Event Counter

This block counts processor events in two 32-bit counters that software sees together as one 64-bit counter register: the upper counter in bits 63:32 and the lower counter in bits 31:0. A single control register selects the event for each counter and holds the privilege-mode count enables and the overflow-interrupt enables. The enables are shared, so both counters always run under the same conditions. A counter that is not in use is parked on an event code that never fires.

Each cycle, the block takes a vector of event pulses, the current privilege mode and a one-word write or read. A counter that wraps from all ones to zero sets its overflow status bit. The interrupt line is raised while a status bit and its matching enable are both set. Any control write clears the status. To sample every N events, software loads a counter with the negative of N.

Top module: `pcp_top`

## Requirements
- R1: After reset, both counters, all control fields and both overflow status bits are zero, and `irq_o` is low.
- R2: A counter write (`wr_sel_i`=0) loads `wr_data_i[63:32]` into the upper counter and `wr_data_i[31:0]` into the lower counter in one cycle. A read with `rd_sel_i`=0 returns the two counters in the same positions.
- R3: A counter increments by exactly one in a cycle when the event pulse at the index given by its select code is high and the enable for the current mode is set. `mode_i` uses 0 for user (enable bit 2), 1 for supervisor (bit 1) and 2 for hypervisor (bit 3). Mode 3 never counts.
- R4: The mode enables gate both counters together. With the current mode's enable clear, neither counter changes.
- R5: The upper counter's 12-bit select code sits in control bits 30:19 and the lower counter's in bits 17:6. A code of `NUM_EVT` or above, such as 0x220, never counts.
- R6: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow status bit, which reads back at bit 33 (upper) or bit 32 (lower) with `rd_sel_i`=1. The status bits change only on a wrap or a control write.
- R7: `irq_o` is high exactly when an overflow status bit is set and its interrupt enable is set: bit 5 for the upper counter, bit 4 for the lower.
- R8: Any control write clears both status bits, and `irq_o` falls after it. A wrap in the same cycle as the write still sets its status bit.
- R9: When a counter write and an event increment fall in the same cycle, the written value is kept.
- R10: A counter loaded with the two's complement of N sets its status bit after exactly N counted events.
- R11: A control read returns the stored control fields in bits 30:0 and zero in bits 0, 18, 31 and 63:34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_EVT | One pulse per event source per cycle |
| mode_i | input | 2 | Current privilege mode (0 user, 1 supervisor, 2 hypervisor) |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | Write target: 0 counter register, 1 control register |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 1 | Read source: 0 counter register, 1 control and status |
| rd_data_o | output | 64 | Read data, combinational from `rd_sel_i` |
| irq_o | output | 1 | Overflow interrupt |

## Verification
On every cycle, the assertions check four things: a counter never moves by more than one step, a disabled counter holds, a load wins over an increment, and the status bits move only on a wrap or a control write. They also check that a control write with no coincident wrap leaves the status and interrupt low. Some behaviour only the bench scenarios can show, against the behavioural model: that the right event index is selected for each counter, the field positions, a parked code staying silent, and the exact N-event sample period. The same goes for the race between a wrap and a control write.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  localparam int CTR_W      = 32;
  localparam int SEL_W      = 12;
  localparam int CTRL_W     = 31;
  localparam int BIT_SUP    = 1;
  localparam int BIT_USR    = 2;
  localparam int BIT_HYP    = 3;
  localparam int IE_LSB     = 4;
  localparam int LO_SEL_LSB = 6;
  localparam int UP_SEL_LSB = 19;

  typedef enum logic [1:0] {
    MODE_USR  = 2'd0,
    MODE_SUP  = 2'd1,
    MODE_HYP  = 2'd2,
    MODE_NONE = 2'd3
  } mode_e;

  function automatic logic [CTRL_W-1:0] ctrl_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    m[BIT_SUP] = 1'b1;
    m[BIT_USR] = 1'b1;
    m[BIT_HYP] = 1'b1;
    m[IE_LSB +: 2] = 2'b11;
    m[LO_SEL_LSB +: SEL_W] = '1;
    m[UP_SEL_LSB +: SEL_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/pcp_ctrl.sv
module pcp_ctrl
  import pcp_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [CTRL_W-1:0]      wr_data_i,
  input  logic [1:0]             mode_i,
  input  logic [1:0]             wrap_i,
  output logic                   cnt_en_o,
  output logic [1:0][SEL_W-1:0]  sel_o,
  output logic [1:0]             ovf_o,
  output logic                   irq_o,
  output logic [CTRL_W-1:0]      ctrl_o
);
  localparam logic [CTRL_W-1:0] MASK = ctrl_mask();

  logic [CTRL_W-1:0] ctrl_q;
  logic [1:0]        ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ovf_q  <= '0;
    end else begin
      if (wr_i) ctrl_q <= wr_data_i & MASK;
      // a wrap coinciding with the clearing write survives
      ovf_q <= (wr_i ? 2'b00 : ovf_q) | wrap_i;
    end
  end

  always_comb begin
    unique case (mode_e'(mode_i))
      MODE_USR: cnt_en_o = ctrl_q[BIT_USR];
      MODE_SUP: cnt_en_o = ctrl_q[BIT_SUP];
      MODE_HYP: cnt_en_o = ctrl_q[BIT_HYP];
      default:  cnt_en_o = 1'b0;
    endcase
  end

  assign sel_o[0] = ctrl_q[LO_SEL_LSB +: SEL_W];
  assign sel_o[1] = ctrl_q[UP_SEL_LSB +: SEL_W];
  assign ovf_o    = ovf_q;
  assign irq_o    = |(ovf_q & ctrl_q[IE_LSB +: 2]);
  assign ctrl_o   = ctrl_q;

  AST_OVF_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i != 2'b00) |=> ((ovf_q & $past(wrap_i)) == $past(wrap_i))); // R6
  AST_OVF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && wrap_i == 2'b00) |=> $stable(ovf_q)); // R6
  AST_WR_CLEARS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wrap_i == 2'b00) |=> (ovf_q == 2'b00)); // R8
endmodule

// File: rtl/pcp_counter.sv
module pcp_counter #(
  parameter int CTR_W   = 32,
  parameter int SEL_W   = 12,
  parameter int NUM_EVT = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               cnt_en_i,
  input  logic               ld_i,
  input  logic [CTR_W-1:0]   ld_val_i,
  output logic [CTR_W-1:0]   cnt_o,
  output logic               wrap_o
);
  localparam int IDX_W = $clog2(NUM_EVT);

  logic [CTR_W-1:0] cnt_q;
  logic             sel_ok, hit, inc;

  // codes past the event vector (parking codes) never fire
  assign sel_ok = sel_i < SEL_W'(NUM_EVT);
  assign hit    = sel_ok && evt_i[sel_i[IDX_W-1:0]];
  assign inc    = cnt_en_i && hit;
  assign wrap_o = inc && !ld_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (ld_i) cnt_q <= ld_val_i;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_q == $past(ld_val_i))); // R9
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !cnt_en_i) |=> $stable(cnt_q)); // R4
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R3
endmodule

// File: rtl/pcp_top.sv
module pcp_top
  import pcp_pkg::*;
#(
  parameter int NUM_EVT = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [1:0]         mode_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [63:0]        wr_data_i,
  input  logic               rd_sel_i,
  output logic [63:0]        rd_data_o,
  output logic               irq_o
);
  localparam int PAD_W = 64 - 2 - 1 - CTRL_W;

  logic                  ctrl_wr, cnt_wr, cnt_en;
  logic [1:0][SEL_W-1:0] sel;
  logic [1:0][CTR_W-1:0] cnt;
  logic [1:0]            wrap, ovf;
  logic [CTRL_W-1:0]     ctrl;

  assign ctrl_wr = wr_en_i &&  wr_sel_i;
  assign cnt_wr  = wr_en_i && !wr_sel_i;

  pcp_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .wr_data_i (wr_data_i[CTRL_W-1:0]),
    .mode_i    (mode_i),
    .wrap_i    (wrap),
    .cnt_en_o  (cnt_en),
    .sel_o     (sel),
    .ovf_o     (ovf),
    .irq_o     (irq_o),
    .ctrl_o    (ctrl)
  );

  // index 0 = lower half, index 1 = upper half
  for (genvar g = 0; g < 2; g++) begin : g_ctr
    pcp_counter #(
      .CTR_W   (CTR_W),
      .SEL_W   (SEL_W),
      .NUM_EVT (NUM_EVT)
    ) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i),
      .sel_i    (sel[g]),
      .cnt_en_i (cnt_en),
      .ld_i     (cnt_wr),
      .ld_val_i (wr_data_i[g*CTR_W +: CTR_W]),
      .cnt_o    (cnt[g]),
      .wrap_o   (wrap[g])
    );
  end

  assign rd_data_o = rd_sel_i ? {{PAD_W{1'b0}}, ovf, 1'b0, ctrl} : {cnt[1], cnt[0]};

  AST_IRQ_LOW_AFTER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wrap == 2'b00) |=> !irq_o); // R7
endmodule

// File: tb/sim_pcp_top.sv
module sim_pcp_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EVT    = 16;
  localparam logic [63:0] CTRL_MASK = 64'h0000_0000_7FFB_FFFE;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_EVT-1:0] evt = '0;
  logic [1:0]         mode = 2'd0;
  logic               we = 1'b0, ws = 1'b0, rs = 1'b0;
  logic [63:0]        wd = '0;
  logic [63:0]        rd;
  logic               irq;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  logic [31:0] m_cnt [2];
  logic [63:0] m_ctrl;
  logic [1:0]  m_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcp_top #(.NUM_EVT(NUM_EVT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .mode_i(mode),
    .wr_en_i(we), .wr_sel_i(ws), .wr_data_i(wd),
    .rd_sel_i(rs), .rd_data_o(rd), .irq_o(irq)
  );

  function automatic logic [63:0] m_read(input logic sel);
    if (sel) return m_ctrl | {30'b0, m_ovf, 32'b0};
    return {m_cnt[1], m_cnt[0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic step(input string tag, input logic [NUM_EVT-1:0] e, input logic [1:0] md,
                      input logic w, input logic wsel, input logic [63:0] wdat, input logic rsel);
    logic en;
    logic [1:0] wrap;
    int code;
    @(negedge clk);
    evt = e; mode = md; we = w; ws = wsel; wd = wdat; rs = rsel;
    #1;
    compared++;
    if (rd !== m_read(rsel)) begin
      mismatched++;
      $display("FAIL %s rd_data got %h exp %h", tag, rd, m_read(rsel));
    end
    compared++;
    if (irq !== |(m_ovf & m_ctrl[5:4])) begin
      mismatched++;
      $display("FAIL %s irq got %b exp %b", tag, irq, |(m_ovf & m_ctrl[5:4]));
    end
    en = (md == 2'd0 && m_ctrl[2]) || (md == 2'd1 && m_ctrl[1]) || (md == 2'd2 && m_ctrl[3]);
    wrap = 2'b00;
    for (int i = 0; i < 2; i++) begin
      code = (i == 0) ? int'(m_ctrl[17:6]) : int'(m_ctrl[30:19]);
      if (w && !wsel) m_cnt[i] = wdat[i*32 +: 32];
      else if (en && code < NUM_EVT && e[code]) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) wrap[i] = 1'b1;
        m_cnt[i] = m_cnt[i] + 32'd1;
      end
    end
    m_ovf = ((w && wsel) ? 2'b00 : m_ovf) | wrap;
    if (w && wsel) m_ctrl = wdat & CTRL_MASK;
  endtask

  task automatic idle(input string tag, input logic rsel);
    step(tag, '0, 2'd0, 1'b0, 1'b0, '0, rsel);
  endtask

  function automatic logic [63:0] mk_ctrl(input int up, input int lo, input logic [2:0] en_hsu,
                                          input logic [1:0] ie);
    logic [63:0] v;
    v = '0;
    v[30:19] = 12'(up);
    v[17:6]  = 12'(lo);
    v[3] = en_hsu[2]; v[1] = en_hsu[1]; v[2] = en_hsu[0];
    v[5:4] = ie;
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_cnt[0] = '0; m_cnt[1] = '0; m_ctrl = '0; m_ovf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle("R1", 1'b0);
    idle("R1", 1'b1);
    // R2 packed write/read
    step("R2", '0, 2'd0, 1'b1, 1'b0, 64'h1111_1111_2222_2222, 1'b0);
    idle("R2", 1'b0);
    // R3 user enable only, lower code 2, upper code 5
    step("R3", '0, 2'd0, 1'b1, 1'b1, mk_ctrl(5, 2, 3'b001, 2'b00), 1'b1);
    step("R3", 16'h0004, 2'd0, 1'b0, 1'b0, '0, 1'b0);
    step("R3", 16'h0020, 2'd0, 1'b0, 1'b0, '0, 1'b0);
    step("R3", 16'h0024, 2'd0, 1'b0, 1'b0, '0, 1'b0);
    step("R3", 16'hFFFF, 2'd3, 1'b0, 1'b0, '0, 1'b0);
    // R4 supervisor/hypervisor disabled: both hold
    step("R4", 16'hFFFF, 2'd1, 1'b0, 1'b0, '0, 1'b0);
    step("R4", 16'hFFFF, 2'd2, 1'b0, 1'b0, '0, 1'b0);
    step("R4", '0, 2'd0, 1'b1, 1'b1, mk_ctrl(5, 2, 3'b110, 2'b00), 1'b0);
    step("R4", 16'hFFFF, 2'd0, 1'b0, 1'b0, '0, 1'b0);
    step("R4", 16'hFFFF, 2'd2, 1'b0, 1'b0, '0, 1'b0);
    step("R4", 16'hFFFF, 2'd1, 1'b0, 1'b0, '0, 1'b0);
    // R5 lower parked on 0x220, upper on code 3
    step("R5", '0, 2'd0, 1'b1, 1'b1, mk_ctrl(3, 'h220, 3'b111, 2'b00), 1'b1);
    for (int i = 0; i < 4; i++) step("R5", 16'hFFFF, 2'd0, 1'b0, 1'b0, '0, 1'b0);
    // R10 period of 5 on lower, R6 status, R7 irq via bit 4
    step("R10", '0, 2'd0, 1'b1, 1'b1, mk_ctrl('h220, 7, 3'b001, 2'b01), 1'b1);
    step("R10", '0, 2'd0, 1'b1, 1'b0, {32'h0, 32'hFFFF_FFFB}, 1'b0);
    for (int i = 0; i < 5; i++) step("R10", 16'h0080, 2'd0, 1'b0, 1'b0, '0, 1'b1);
    idle("R6", 1'b1);
    idle("R7", 1'b0);
    // R8 control write clears status and irq
    step("R8", '0, 2'd0, 1'b1, 1'b1, mk_ctrl('h220, 7, 3'b001, 2'b01), 1'b1);
    idle("R8", 1'b1);
    // R8 wrap in same cycle as control write survives
    step("R8", '0, 2'd0, 1'b1, 1'b0, {32'h0, 32'hFFFF_FFFF}, 1'b1);
    step("R8", 16'h0080, 2'd0, 1'b1, 1'b1, mk_ctrl('h220, 7, 3'b001, 2'b11), 1'b1);
    idle("R8", 1'b1);
    // R7 upper overflow with bit 5 masked, then enabled
    step("R7", '0, 2'd0, 1'b1, 1'b1, mk_ctrl(1, 'h220, 3'b001, 2'b01), 1'b1);
    step("R7", '0, 2'd0, 1'b1, 1'b0, {32'hFFFF_FFFF, 32'h0}, 1'b0);
    step("R7", 16'h0002, 2'd0, 1'b0, 1'b0, '0, 1'b1);
    idle("R7", 1'b1);
    step("R7", '0, 2'd0, 1'b1, 1'b1, mk_ctrl(1, 'h220, 3'b001, 2'b10), 1'b1);
    idle("R7", 1'b1);
    // R9 counter write beats increment
    step("R9", '0, 2'd0, 1'b1, 1'b1, mk_ctrl(0, 0, 3'b001, 2'b00), 1'b0);
    step("R9", 16'h0001, 2'd0, 1'b1, 1'b0, 64'hABCD_0000_0000_1234, 1'b0);
    idle("R9", 1'b0);
    // R11 control readback mask
    step("R11", '0, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    idle("R11", 1'b1);
    // random mix checked every cycle
    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      int r;
      r = int'($urandom_range(0, 19));
      d = {$urandom, $urandom};
      if (r == 0)
        step("R3", NUM_EVT'($urandom), 2'($urandom), 1'b1, 1'b1,
             mk_ctrl(int'($urandom_range(0, NUM_EVT + 1)), int'($urandom_range(0, NUM_EVT + 1)),
                     3'($urandom), 2'($urandom)), 1'($urandom));
      else if (r == 1)
        step("R9", NUM_EVT'($urandom), 2'($urandom), 1'b1, 1'b0,
             {32'hFFFF_FFF0 | 32'(d[35:32]), 32'hFFFF_FFF0 | 32'(d[3:0])}, 1'($urandom));
      else
        step("R6", NUM_EVT'($urandom), 2'($urandom), 1'b0, 1'b0, '0, 1'($urandom));
    end
    finish_run();
  end
endmodule